// File: doc/BRIEF.md
# Weighted Rx/Tx DMA Bus Arbiter

This block decides which of two DMA engines, a receive engine and a transmit engine, may drive a shared host bus master port. Each grant covers one burst. The burst ends when the bus side flags the last beat, or when the programmed number of beats has completed, whichever comes first. A new owner is chosen only at a burst boundary, or when the port is idle.

Two arbitration schemes are available. In the weighted scheme, a 2-bit ratio field lets the receive engine win up to one, two, three or four bursts in a row while both engines are asking; after that the transmit engine gets one burst. In the strict scheme the receive engine always wins and the ratio field is ignored. The burst length is programmable to a power of two from 1 to 32. A length outside that set raises an error flag, and the burst length is clamped to a single beat.

A one-cycle soft-reset pulse flushes the arbiter. It drops both grants, clears the weighted run counter and holds the port idle for four cycles. It reports busy until the flush is done.

Top module: `dma_bus_arb`

## Requirements
- R1: In weighted mode (cfg_rx_strict=0), while both engines request continuously, the grants follow a repeating pattern of N receive bursts then one transmit burst, where N = cfg_ratio + 1 (ratio 0 gives 1:1, 1 gives 2:1, 2 gives 3:1, 3 gives 4:1).
- R2: In weighted mode, a lone requester is granted every burst. A receive engine that has won N or more consecutive bursts yields the next burst to the transmit engine as soon as that engine requests.
- R3: In strict mode (cfg_rx_strict=1), the receive engine wins every decision at which it requests, whatever cfg_ratio holds. The transmit engine is granted only at a decision where the receive engine is not requesting.
- R4: A grant stays unchanged until its burst ends. A burst ends at a beat_done cycle that has last_beat high, or at the beat_done cycle that completes burst_beats beats. Cycles without beat_done never end a burst.
- R5: burst_beats shows the burst length captured when the current grant started. It stays stable for the whole burst, and a valid programmed length (1, 2, 4, 8, 16 or 32) is reproduced exactly.
- R6: cfg_err is high one cycle after cfg_burst_len holds a value outside {1, 2, 4, 8, 16, 32}, and low one cycle after it holds one of them. Bursts started under an invalid length last one beat.
- R7: A soft_rst_set pulse makes soft_rst_busy high for exactly 4 cycles, starting at the next clock edge. Both grants are low from that edge until one cycle after soft_rst_busy falls.
- R8: Soft reset clears the weighted run counter, so the first N bursts after it go to the receive engine when both request.
- R9: Starting from idle, a request is granted at the next clock edge. A grant never rises without its request having been high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ratio | input | 2 | Receive:transmit weight, N = value + 1 |
| cfg_rx_strict | input | 1 | 1 selects strict receive priority |
| cfg_burst_len | input | 6 | Programmed beats per burst |
| soft_rst_set | input | 1 | One-cycle pulse that starts a soft reset |
| soft_rst_busy | output | 1 | High while the soft reset runs |
| rx_req | input | 1 | Receive engine requests the port |
| tx_req | input | 1 | Transmit engine requests the port |
| beat_done | input | 1 | A beat of the current burst completed |
| last_beat | input | 1 | The completing beat is the final one |
| rx_gnt | output | 1 | Receive engine owns the port |
| tx_gnt | output | 1 | Transmit engine owns the port |
| burst_beats | output | 6 | Beat count of the current burst |
| cfg_err | output | 1 | Programmed burst length is invalid |

## Verification
Grants are registered. A request seen while idle, or at the cycle where a burst ends, shows up as a grant one edge later. The bench therefore drives at the falling edge and checks the owner at each following falling edge, across every ratio and several burst lengths. cfg_err follows cfg_burst_len one edge later, and it is swept over all 64 codes with one check per code. After a soft-reset pulse, busy is checked on the next four falling edges, the idle gap on the fifth and the first receive grant on the sixth.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_RX   = 2'd1,
        OWN_TX   = 2'd2
    } owner_e;
endpackage

// File: rtl/arb_len_check.sv
`timescale 1ns/1ps
module arb_len_check #(
    parameter int MAX_BURST = 32,
    parameter int BL_W      = $clog2(MAX_BURST) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BL_W-1:0] len_in,
    output logic [BL_W-1:0] len_q,
    output logic            err_q
);
    localparam int NSTEP = $clog2(MAX_BURST) + 1;

    typedef struct packed {
        logic [BL_W-1:0] len;
        logic            err;
    } lc_t;

    lc_t st_d, st_q;
    logic legal;

    always_comb begin
        legal = 1'b0;
        for (int i = 0; i < NSTEP; i++) begin
            if (len_in == BL_W'(1 << i)) legal = 1'b1;
        end
        st_d.err = ~legal;
        st_d.len = legal ? len_in : BL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.len <= BL_W'(1);
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_q = st_q.len;
    assign err_q = st_q.err;

    // R6
    err_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(len_in) == BL_W'(3) |-> (err_q && len_q == BL_W'(1)));
endmodule

// File: rtl/arb_soft_reset.sv
`timescale 1ns/1ps
module arb_soft_reset #(
    parameter int HOLD = 4,
    parameter int CW   = $clog2(HOLD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } sr_t;

    sr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == CW'(HOLD - 1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/arb_core.sv
`timescale 1ns/1ps
module arb_core
    import arb_pkg::*;
#(
    parameter int BL_W    = 6,
    parameter int RATIO_W = 2,
    parameter int RUN_MAX = 1 << RATIO_W,
    parameter int RUN_W   = $clog2(RUN_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               rx_req,
    input  logic               tx_req,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               rx_strict,
    input  logic [BL_W-1:0]    len_in,
    input  logic               beat_done,
    input  logic               last_beat,
    output logic               rx_gnt,
    output logic               tx_gnt,
    output logic [BL_W-1:0]    burst_beats
);
    typedef struct packed {
        owner_e          owner;
        logic [RUN_W-1:0] rx_run;
        logic [BL_W-1:0]  beat_cnt;
        logic [BL_W-1:0]  len;
    } core_t;

    core_t st_d, st_q;
    logic burst_end, decide;
    logic [RUN_W-1:0] n_need;
    owner_e pick;

    always_comb begin
        n_need    = RUN_W'(ratio) + RUN_W'(1);
        burst_end = (st_q.owner != OWN_NONE) && beat_done &&
                    (last_beat || (st_q.beat_cnt == st_q.len - BL_W'(1)));
        decide    = (st_q.owner == OWN_NONE) || burst_end;

        if (rx_strict) begin
            pick = rx_req ? OWN_RX : (tx_req ? OWN_TX : OWN_NONE);
        end else if (rx_req && tx_req) begin
            pick = (st_q.rx_run >= n_need) ? OWN_TX : OWN_RX;
        end else begin
            pick = rx_req ? OWN_RX : (tx_req ? OWN_TX : OWN_NONE);
        end

        st_d = st_q;
        if (st_q.owner != OWN_NONE && beat_done) begin
            st_d.beat_cnt = st_q.beat_cnt + BL_W'(1);
        end
        if (decide) begin
            st_d.owner    = pick;
            st_d.beat_cnt = '0;
            if (pick != OWN_NONE) st_d.len = len_in;
            if (pick == OWN_RX && st_q.rx_run != RUN_W'(RUN_MAX)) begin
                st_d.rx_run = st_q.rx_run + RUN_W'(1);
            end
            if (pick == OWN_TX) st_d.rx_run = '0;
        end
        if (flush) begin
            st_d.owner    = OWN_NONE;
            st_d.rx_run   = '0;
            st_d.beat_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.owner    <= OWN_NONE;
            st_q.rx_run   <= '0;
            st_q.beat_cnt <= '0;
            st_q.len      <= BL_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_gnt      = (st_q.owner == OWN_RX);
    assign tx_gnt      = (st_q.owner == OWN_TX);
    assign burst_beats = st_q.len;

    // R4
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner != OWN_NONE && !burst_end && !flush) |=> $stable(st_q.owner));

    // R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner != OWN_NONE && !burst_end && !flush) |=> $stable(burst_beats));

    // R3
    strict_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && rx_strict && rx_req && !flush) |=> rx_gnt);

    // R1
    weight_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !rx_strict && rx_req && tx_req && st_q.rx_run >= n_need && !flush)
        |=> tx_gnt);
endmodule

// File: rtl/dma_bus_arb.sv
`timescale 1ns/1ps
module dma_bus_arb #(
    parameter int MAX_BURST = 32,
    parameter int RATIO_W   = 2,
    parameter int HOLD      = 4,
    parameter int BL_W      = $clog2(MAX_BURST) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               cfg_rx_strict,
    input  logic [BL_W-1:0]    cfg_burst_len,
    input  logic               soft_rst_set,
    output logic               soft_rst_busy,
    input  logic               rx_req,
    input  logic               tx_req,
    input  logic               beat_done,
    input  logic               last_beat,
    output logic               rx_gnt,
    output logic               tx_gnt,
    output logic [BL_W-1:0]    burst_beats,
    output logic               cfg_err
);
    logic [BL_W-1:0] len_clean;
    logic flush;

    arb_len_check #(.MAX_BURST(MAX_BURST), .BL_W(BL_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .len_in (cfg_burst_len),
        .len_q  (len_clean),
        .err_q  (cfg_err)
    );

    arb_soft_reset #(.HOLD(HOLD)) u_sreset (
        .clk   (clk),
        .rst_n (rst_n),
        .start (soft_rst_set),
        .busy  (soft_rst_busy)
    );

    assign flush = soft_rst_set | soft_rst_busy;

    arb_core #(.BL_W(BL_W), .RATIO_W(RATIO_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .rx_req      (rx_req),
        .tx_req      (tx_req),
        .ratio       (cfg_ratio),
        .rx_strict   (cfg_rx_strict),
        .len_in      (len_clean),
        .beat_done   (beat_done),
        .last_beat   (last_beat),
        .rx_gnt      (rx_gnt),
        .tx_gnt      (tx_gnt),
        .burst_beats (burst_beats)
    );

    // R7
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_busy |=> (!rx_gnt && !tx_gnt));

    // R9
    rx_req_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_gnt) |-> $past(rx_req));

    // R9
    tx_req_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_gnt) |-> $past(tx_req));

    // R6
    clamp_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_gnt) && $past(cfg_err)) |-> burst_beats == BL_W'(1));
endmodule

// File: tb/dma_bus_arb_bench.sv
`timescale 1ns/1ps
module dma_bus_arb_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_ratio;
    logic       cfg_rx_strict;
    logic [5:0] cfg_burst_len;
    logic       soft_rst_set;
    logic       soft_rst_busy;
    logic       rx_req, tx_req, beat_done, last_beat;
    logic       rx_gnt, tx_gnt;
    logic [5:0] burst_beats;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_bus_arb u_dma_bus_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_ratio     (cfg_ratio),
        .cfg_rx_strict (cfg_rx_strict),
        .cfg_burst_len (cfg_burst_len),
        .soft_rst_set  (soft_rst_set),
        .soft_rst_busy (soft_rst_busy),
        .rx_req        (rx_req),
        .tx_req        (tx_req),
        .beat_done     (beat_done),
        .last_beat     (last_beat),
        .rx_gnt        (rx_gnt),
        .tx_gnt        (tx_gnt),
        .burst_beats   (burst_beats),
        .cfg_err       (cfg_err)
    );

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic soft_reset;
        rx_req = 0; tx_req = 0; beat_done = 0; last_beat = 0;
        soft_rst_set = 1;
        step;
        soft_rst_set = 0;
        repeat (5) step;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lens[4];
        lens[0] = 1; lens[1] = 2; lens[2] = 4; lens[3] = 8;
        rst_n = 0; cfg_ratio = 0; cfg_rx_strict = 0; cfg_burst_len = 6'd1;
        soft_rst_set = 0; rx_req = 0; tx_req = 0; beat_done = 0; last_beat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step;
        // reset state
        check("R9 reset rx_gnt", int'(rx_gnt), 0);
        check("R9 reset tx_gnt", int'(tx_gnt), 0);
        check("R7 reset busy", int'(soft_rst_busy), 0);
        check("R6 reset err", int'(cfg_err), 0);

        // R1 / R5 / R8: weighted sweep over ratios and lengths, fresh soft reset each time
        for (int r = 0; r < 4; r++) begin
            for (int li = 0; li < 4; li++) begin
                int n, run, L;
                bit exp_rx;
                n = r + 1; run = 0; L = lens[li];
                cfg_ratio = 2'(r); cfg_rx_strict = 0; cfg_burst_len = 6'(L);
                soft_reset;
                rx_req = 1; tx_req = 1; beat_done = 1;
                step;
                for (int b = 0; b < 2 * (n + 1); b++) begin
                    if (run >= n) begin exp_rx = 0; run = 0; end
                    else begin exp_rx = 1; run = (run < 4) ? run + 1 : 4; end
                    for (int c = 0; c < L; c++) begin
                        check("R1 rx owner", int'(rx_gnt), int'(exp_rx));
                        check("R1 tx owner", int'(tx_gnt), int'(!exp_rx));
                        if (c == 0) check("R5 burst_beats", int'(burst_beats), L);
                        step;
                    end
                end
            end
        end

        // R7 / R8: soft reset during activity, then counter restarts at ratio 3
        cfg_ratio = 2'd3; cfg_burst_len = 6'd1;
        soft_rst_set = 1;
        step;
        soft_rst_set = 0;
        for (int k = 0; k < 4; k++) begin
            check("R7 busy high", int'(soft_rst_busy), 1);
            check("R7 grants low", int'(rx_gnt | tx_gnt), 0);
            step;
        end
        check("R7 busy fell", int'(soft_rst_busy), 0);
        check("R7 idle gap", int'(rx_gnt | tx_gnt), 0);
        step;
        for (int k = 0; k < 4; k++) begin
            check("R8 rx after flush", int'(rx_gnt), 1);
            step;
        end
        check("R8 tx after four rx", int'(tx_gnt), 1);

        // R4: grant held without beats, ended early by last_beat, then by count
        cfg_ratio = 2'd0; cfg_burst_len = 6'd8;
        soft_reset;
        rx_req = 1;
        step;
        check("R9 grant one edge after request", int'(rx_gnt), 1);
        for (int k = 0; k < 3; k++) begin
            step;
            check("R4 held without beats", int'(rx_gnt), 1);
        end
        check("R5 length during burst", int'(burst_beats), 8);
        tx_req = 1; beat_done = 1;
        step; step;
        last_beat = 1;
        check("R4 held before last beat", int'(rx_gnt), 1);
        step;
        last_beat = 0;
        check("R4 switch after last beat", int'(tx_gnt), 1);
        for (int k = 0; k < 8; k++) begin
            check("R4 tx held for count", int'(tx_gnt), 1);
            step;
        end
        check("R4 rx after counted burst", int'(rx_gnt), 1);

        // R3: strict priority ignores ratio
        cfg_rx_strict = 1; cfg_ratio = 2'd3; cfg_burst_len = 6'd1;
        soft_reset;
        rx_req = 1; tx_req = 1; beat_done = 1;
        step;
        for (int k = 0; k < 10; k++) begin
            check("R3 strict rx", int'(rx_gnt), 1);
            check("R3 strict no tx", int'(tx_gnt), 0);
            step;
        end
        rx_req = 0;
        step;
        check("R3 tx when rx idle", int'(tx_gnt), 1);
        rx_req = 1;
        step;
        check("R3 rx returns", int'(rx_gnt), 1);

        // R2: lone requesters, then yield after saturation
        cfg_rx_strict = 0; cfg_ratio = 2'd3; cfg_burst_len = 6'd1;
        soft_reset;
        tx_req = 1; beat_done = 1;
        step;
        for (int k = 0; k < 5; k++) begin
            check("R2 lone tx", int'(tx_gnt), 1);
            step;
        end
        tx_req = 0; rx_req = 1;
        step;
        for (int k = 0; k < 6; k++) begin
            check("R2 lone rx", int'(rx_gnt), 1);
            if (k < 5) step;
        end
        tx_req = 1;
        step;
        check("R2 yield to tx", int'(tx_gnt), 1);

        // R6: invalid length grants one-beat bursts
        cfg_ratio = 2'd0; cfg_burst_len = 6'd3;
        soft_reset;
        check("R6 err for 3", int'(cfg_err), 1);
        rx_req = 1; tx_req = 1; beat_done = 1;
        step;
        for (int k = 0; k < 4; k++) begin
            check("R6 clamp beats", int'(burst_beats), 1);
            check("R6 alternating", int'(rx_gnt), (k % 2 == 0) ? 1 : 0);
            step;
        end

        // R6: every length code
        rx_req = 0; tx_req = 0; beat_done = 0;
        for (int v = 0; v < 64; v++) begin
            int ok;
            cfg_burst_len = 6'(v);
            step;
            ok = (v == 1 || v == 2 || v == 4 || v == 8 || v == 16 || v == 32) ? 1 : 0;
            check("R6 err code", int'(cfg_err), 1 - ok);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule